// File: doc/BRIEF.md
# Page Staging Buffer with In-Page Wrap

This block gathers the data bytes of one serial write burst into a one-page staging area, and then commits them to a nonvolatile array as one timed write cycle. The burst starts with a start-address load that carries a page-row number and a starting byte offset inside that page. A series of byte strobes follows. Each accepted byte goes into the staging slot at the current offset. Only the low offset bits then advance, so a burst that runs past the last byte of the page wraps to the first byte of the same row. Any byte that lands on a slot already used in the burst replaces the earlier one.

An end-of-burst strobe, which stands in for the stop condition of the serial link, starts the commit. The commit sequencer walks the page offsets in ascending order, one per clock. It drives the memory-side write port only for the offsets that the burst actually filled. It then keeps the busy flag high until a fixed write-cycle timer runs out. While the buffer is busy, every input strobe is ignored. A one-cycle done pulse marks the end of the cycle. An end-of-burst strobe that arrives when no bytes have been staged changes nothing.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are all low.
- R2: An accepted start-address load (load_i) sets the page row to load_row_i and the offset to load_offs_i, and it discards every byte staged since the previous load, so those bytes are never committed. Load has priority over a byte strobe and over an end strobe in the same cycle.
- R3: Each accepted byte strobe (byte_vld_i) stores byte_i at the current offset and then increments the offset by one. The page row never changes because of bytes.
- R4: When a byte is accepted at the last offset (2**OFFS_W-1), the next byte goes to offset 0 of the same row.
- R5: A byte delivered to an offset that is already staged in the same burst replaces the earlier byte, and only the newest value is committed.
- R6: During a commit, the slot at offset k is examined in busy cycle k (counting from 0), in ascending order. mem_we_o pulses only for staged offsets. mem_addr_o is {row, offset} with the row in the upper ROW_W bits, and mem_data_o is the staged byte.
- R7: An accepted end-of-burst strobe (end_i) with at least one staged byte raises busy_o in the next cycle. busy_o then stays high for exactly WR_CYCLES cycles.
- R8: done_o pulses high for exactly one cycle, in the first cycle after busy_o falls.
- R9: While busy_o is high, load_i, byte_vld_i and end_i have no effect on the staged bytes, the row or the offset.
- R10: An accepted end-of-burst strobe with no staged bytes does not raise busy_o and produces no memory writes.
- R11: A completed commit empties the staging area, so a later end-of-burst strobe with no new bytes behaves as in R10. The row and the offset carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start-address load strobe |
| load_row_i | input | ROW_W | Page row to load |
| load_offs_i | input | OFFS_W | Starting byte offset inside the page |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| end_i | input | 1 | End-of-burst strobe (starts the commit) |
| busy_o | output | 1 | Commit and write cycle in progress |
| done_o | output | 1 | One-cycle pulse when the write cycle ends |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ROW_W+OFFS_W | Array byte address {row, offset} |
| mem_data_o | output | DATA_W | Array write data |

## Verification
The bench runs four kinds of burst:
- A short burst from a mid-page offset. It separates correct offset stepping and row placement from a design that writes from offset 0.
- A burst of more than a page starting near the top of the page. Its overwrites tell an in-page wrap apart from a carry into the row, and newest-value-wins apart from first-value-wins.
- A burst that is discarded by a fresh load. It shows that the load clears the staging area.
- End strobes on an empty staging area, plus strobes sent during a busy cycle. These show that empty commits and strobes while busy leave the later write stream and the busy timing unchanged.

A scoreboard also checks the cycle slot of each write inside the busy window. This catches a commit that runs in the wrong order or skips timing.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic {
      CS_IDLE   = 1'b0,
      CS_COMMIT = 1'b1
   } cstate_t;
endpackage

// File: rtl/pgbuf_addr.sv
// Row and offset register; only the offset advances on each byte.
module pgbuf_addr #(
   parameter int ROW_W  = 6,
   parameter int OFFS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [OFFS_W-1:0] offs_in,
   input  logic              adv,
   input  logic              busy,
   output logic [ROW_W-1:0]  row,
   output logic [OFFS_W-1:0] offs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row  <= '0;
         offs <= '0;
      end else if (load) begin
         row  <= row_in;
         offs <= offs_in;
      end else if (adv) begin
         offs <= offs + 1'b1;
      end
   end

   AST_OFFS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && offs == '1) |=> (offs == '0)); // R4
   AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!load) |=> $stable(row)); // R3
   AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(row) && $stable(offs))); // R9
endmodule

// File: rtl/pgbuf_store.sv
// One page of staging slots, each with a valid flag.
module pgbuf_store #(
   parameter int DATA_W = 8,
   parameter int OFFS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [OFFS_W-1:0] wr_offs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFFS_W-1:0] rd_offs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              any_vld
);
   localparam int SLOTS = 1 << OFFS_W;

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [SLOTS-1:0]  vld_q;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
            vld_q[s]  <= 1'b0;
         end else if (clr) begin
            vld_q[s]  <= 1'b0;
         end else if (wr && wr_offs == OFFS_W'(s)) begin
            slot_q[s] <= wr_data;
            vld_q[s]  <= 1'b1;
         end
      end
   end

   assign rd_data = slot_q[rd_offs];
   assign rd_vld  = vld_q[rd_offs];
   assign any_vld = |vld_q;

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any_vld); // R2
   AST_WR_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> any_vld); // R3
endmodule

// File: rtl/pgbuf_commit.sv
// Commit sequencer: scans offsets one per clock, then runs out the timer.
module pgbuf_commit
   import pgbuf_pkg::*;
#(
   parameter int OFFS_W    = 4,
   parameter int WR_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              scan_act,
   output logic [OFFS_W-1:0] scan_offs,
   output logic              fin,
   output logic              done
);
   localparam int CNT_W = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(1 << OFFS_W);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);

   cstate_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            CS_IDLE: if (start) begin
               st_q  <= CS_COMMIT;
               cnt_q <= '0;
            end
            CS_COMMIT: if (cnt_q == LAST_CNT) begin
               st_q   <= CS_IDLE;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= CS_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == CS_COMMIT);
   assign scan_act  = busy && (cnt_q < PAGE_CNT);
   assign scan_offs = cnt_q[OFFS_W-1:0];
   assign fin       = busy && (cnt_q == LAST_CNT);
   assign done      = done_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R8
   AST_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (!busy && done)); // R7
endmodule

// File: rtl/pgbuf_top.sv
// Page staging buffer: stage a burst with in-page wrap, commit, time out.
module pgbuf_top
   import pgbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OFFS_W    = 4,
   parameter int ROW_W     = 6,
   parameter int WR_CYCLES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [ROW_W-1:0]        load_row_i,
   input  logic [OFFS_W-1:0]       load_offs_i,
   input  logic                    byte_vld_i,
   input  logic [DATA_W-1:0]       byte_i,
   input  logic                    end_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    mem_we_o,
   output logic [ROW_W+OFFS_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0]       mem_data_o
);
   localparam int PAGE = 1 << OFFS_W;

   if (WR_CYCLES < PAGE) begin : g_bad_cycles
      $error("WR_CYCLES must cover one scan of the page");
   end
   if (DATA_W < 1 || OFFS_W < 1 || ROW_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   logic              busy, fin, scan_act, any_vld, rd_vld, start;
   logic              acc_load, acc_byte, acc_end;
   logic [ROW_W-1:0]  row;
   logic [OFFS_W-1:0] offs, scan_offs;
   logic [DATA_W-1:0] rd_data;

   // Priority: load, then byte, then end; all are ignored while busy.
   assign acc_load = load_i && !busy;
   assign acc_byte = byte_vld_i && !busy && !load_i;
   assign acc_end  = end_i && !busy && !load_i && !byte_vld_i;
   assign start    = acc_end && any_vld;

   pgbuf_addr #(.ROW_W(ROW_W), .OFFS_W(OFFS_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(acc_load), .row_in(load_row_i),
      .offs_in(load_offs_i), .adv(acc_byte), .busy(busy), .row(row), .offs(offs)
   );

   pgbuf_store #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(acc_load || fin), .wr(acc_byte),
      .wr_offs(offs), .wr_data(byte_i), .rd_offs(scan_offs),
      .rd_data(rd_data), .rd_vld(rd_vld), .any_vld(any_vld)
   );

   pgbuf_commit #(.OFFS_W(OFFS_W), .WR_CYCLES(WR_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .scan_act(scan_act),
      .scan_offs(scan_offs), .fin(fin), .done(done_o)
   );

   assign busy_o     = busy;
   assign mem_we_o   = scan_act && rd_vld;
   assign mem_addr_o = {row, scan_offs};
   assign mem_data_o = rd_data;

   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o); // R6
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_o); // R7
   AST_EMPTY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_end && !any_vld) |=> !busy_o); // R10
   AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o) |-> !mem_we_o); // R11
endmodule

// File: tb/pgbuf_top_test.sv
module pgbuf_top_test;
   localparam int DW = 8, OW = 4, RW = 6, WR = 40, PG = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_i = 0, byte_vld_i = 0, end_i = 0;
   logic [RW-1:0] load_row_i = '0;
   logic [OW-1:0] load_offs_i = '0;
   logic [DW-1:0] byte_i = '0;
   logic busy_o, done_o, mem_we_o;
   logic [RW+OW-1:0] mem_addr_o;
   logic [DW-1:0] mem_data_o;

   int total = 0, bad = 0;

   pgbuf_top #(.DATA_W(DW), .OFFS_W(OW), .ROW_W(RW), .WR_CYCLES(WR)) uut (.*);

   always #10 clk = ~clk;  // 50 MHz

   // bench model of the staging state
   logic [RW-1:0] m_row = '0;
   logic [OW-1:0] m_offs = '0;
   logic [DW-1:0] m_data [PG];
   logic [PG-1:0] m_vld = '0;
   logic [RW+OW+DW-1:0] sb_q [$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pop expected writes and check their slot in the busy window
   int bcyc = 0;
   always @(negedge clk) begin
      if (rst_n && mem_we_o) begin
         if (sb_q.size() == 0) begin
            check(0, "R6 unexpected write", int'(mem_addr_o), 0);
         end else begin
            logic [RW+OW+DW-1:0] e;
            e = sb_q.pop_front();
            check({mem_addr_o, mem_data_o} == e, "R6 write addr/data",
                  int'({mem_addr_o, mem_data_o}), int'(e));
            check(int'(mem_addr_o[OW-1:0]) == bcyc, "R6 write slot",
                  bcyc, int'(mem_addr_o[OW-1:0]));
         end
      end
      bcyc = busy_o ? bcyc + 1 : 0;
   end

   task automatic do_load(input logic [RW-1:0] r, input logic [OW-1:0] o);
      @(negedge clk); load_i = 1; load_row_i = r; load_offs_i = o;
      @(negedge clk); load_i = 0;
      m_row = r; m_offs = o; m_vld = '0;  // R2
   endtask

   task automatic put(input logic [DW-1:0] b);
      @(negedge clk); byte_vld_i = 1; byte_i = b;
      @(negedge clk); byte_vld_i = 0;
      m_data[m_offs] = b; m_vld[m_offs] = 1'b1; m_offs = m_offs + 1'b1;  // R3 R4 R5
   endtask

   // end strobe; checks busy length and the done pulse
   task automatic finish_burst(input bit junk_while_busy);
      int n = 0;
      bit expect_busy;
      expect_busy = |m_vld;
      for (int k = 0; k < PG; k++)
         if (m_vld[k]) sb_q.push_back({m_row, OW'(k), m_data[k]});
      m_vld = '0;
      @(negedge clk); end_i = 1;
      @(negedge clk); end_i = 0;
      if (!expect_busy) begin
         for (int k = 0; k < 4; k++) begin
            check(!busy_o, "R10 no busy on empty end", int'(busy_o), 0);
            @(negedge clk);
         end
         return;
      end
      if (junk_while_busy) begin  // R9
         load_i = 1; load_row_i = 6'h3F; load_offs_i = 4'h9;
         byte_vld_i = 1; byte_i = 8'hEE; end_i = 1;
         @(negedge clk);
         n++;
         load_i = 0; byte_vld_i = 0; end_i = 0;
      end
      while (busy_o && n < WR + 10) begin
         n++;
         @(negedge clk);
      end
      check(n == WR, "R7 busy length", n, WR);
      check(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
      @(negedge clk);
      check(done_o == 1'b0, "R8 done single", int'(done_o), 0);
      check(sb_q.size() == 0, "R6 all writes seen", sb_q.size(), 0);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < PG; k++) m_data[k] = '0;
      #5;
      check(!busy_o && !done_o && !mem_we_o, "R1 reset outputs",
            int'({busy_o, done_o, mem_we_o}), 0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!busy_o && !done_o && !mem_we_o, "R1 after reset",
            int'({busy_o, done_o, mem_we_o}), 0);

      // R3 short burst from mid-page
      do_load(6'h05, 4'h6);
      put(8'h11); put(8'h22); put(8'h33);
      finish_burst(0);

      // R4 R5 wrap and overwrite: 20 bytes starting at offset 14
      do_load(6'h2A, 4'hE);
      for (int k = 0; k < 20; k++) put(DW'(8'h40 + k));
      finish_burst(0);

      // R11 second end with nothing staged
      finish_burst(0);

      // R2 staged bytes discarded by a fresh load
      do_load(6'h01, 4'h0);
      put(8'hA1); put(8'hA2);
      do_load(6'h02, 4'h3);
      put(8'hB0);
      finish_burst(0);

      // R10 end on an empty page right after a load
      do_load(6'h07, 4'h2);
      finish_burst(0);

      // R9 strobes while busy are ignored; row/offset carry over (R11)
      do_load(6'h10, 4'hF);
      put(8'hC1);
      finish_burst(1);
      finish_burst(0);   // junk byte must not have been staged
      put(8'hD5);        // continues at row 0x10, offset 0
      finish_burst(0);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule